// File: doc/BRIEF.md
# Two-Cycle High Detector (Moore and Mealy pair)

The block watches a single serial bit and raises a flag when that bit has been high on two consecutive clock cycles. It builds the same detection twice, side by side, so that the two classic state machine styles can be compared on one input stream. The first machine registers its result. Its flag is a function of state alone and moves only on a rising clock edge. The second machine combines its state with the live input. Its flag responds within the cycle and leads the registered flag by one clock.

The registered machine needs three states: nothing seen, one high seen, and two or more highs in a row. The input-driven machine needs only two states, holding whether the last sampled bit was high. Both machines share one active-low asynchronous reset, which returns them to the state where no high has been seen.

Top module: `pair_high_detect`

## Requirements
- R1: While rst_ni is low, z_moore_o and z_mealy_o are both 0, whatever the value of x_i. The machines leave reset in the state where no high has been seen.
- R2: After a rising edge, z_moore_o is 1 if and only if x_i was sampled 1 at that edge and also at the edge before it, counting only edges since reset was released.
- R3: Between edges, z_mealy_o is 1 if and only if x_i was sampled 1 at the most recent edge since reset and the present x_i is 1.
- R4: At every rising edge after the first since reset, the new z_moore_o equals the value z_mealy_o had just before that edge.
- R5: z_moore_o does not change between rising edges, even when x_i toggles.
- R6: When x_i goes low between edges, z_mealy_o goes low in the same cycle, without waiting for an edge.
- R7: A single sampled high with a low on either side asserts neither output.
- R8: While x_i stays high, z_moore_o stays 1 at every edge from the second high sample onward. z_mealy_o is 1 from the cycle after the first high sample onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_i | input | 1 | Serial bit under observation |
| z_moore_o | output | 1 | Registered detection flag (state only) |
| z_mealy_o | output | 1 | Early detection flag (state and live input) |

## Verification
The assertions assume that x_i is a clean synchronous level: it does not change in the sampling window around a rising edge, and it is never X or Z once reset is released. The bench drives x_i only on the falling edge and within the low phase, so every sample the design takes is the value the reference model records. Mid-cycle toggles are placed well before the next rising edge, so the in-cycle behaviour of the input-driven flag can be observed without disturbing the sampled history.

// File: rtl/pair_high_pkg.sv
package pair_high_pkg;

  // Registered detector: count of consecutive high samples, saturating at two
  typedef enum logic [1:0] {
    MO_NONE = 2'd0,
    MO_ONE  = 2'd1,
    MO_RUN  = 2'd2
  } moore_state_e;

  // Input-driven detector: last sampled level
  typedef enum logic {
    ME_LOW  = 1'b0,
    ME_HIGH = 1'b1
  } mealy_state_e;

endpackage

// File: rtl/pair_high_moore.sv
module pair_high_moore
  import pair_high_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic x_i,
  output logic z_o
);

  moore_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      MO_NONE: state_d = x_i ? MO_ONE : MO_NONE;
      MO_ONE:  state_d = x_i ? MO_RUN : MO_NONE;
      MO_RUN:  state_d = x_i ? MO_RUN : MO_NONE;
      default: state_d = MO_NONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= MO_NONE;
    else         state_q <= state_d;
  end

  // Output decoded from state only
  assign z_o = (state_q == MO_RUN);

endmodule

// File: rtl/pair_high_mealy.sv
module pair_high_mealy
  import pair_high_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic x_i,
  output logic z_o
);

  mealy_state_e state_q, state_d;

  always_comb begin
    state_d = x_i ? ME_HIGH : ME_LOW;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ME_LOW;
    else         state_q <= state_d;
  end

  // Output on the arc: state qualified by the live input
  always_comb begin
    unique case (state_q)
      ME_HIGH: z_o = x_i;
      default: z_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/pair_high_detect.sv
module pair_high_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic x_i,
  output logic z_moore_o,
  output logic z_mealy_o
);

  logic z_moore_raw, z_mealy_raw;

  pair_high_moore u_moore (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .x_i    (x_i),
    .z_o    (z_moore_raw)
  );

  pair_high_mealy u_mealy (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .x_i    (x_i),
    .z_o    (z_mealy_raw)
  );

  // Force both flags low while reset is held
  assign z_moore_o = rst_ni & z_moore_raw;
  assign z_mealy_o = rst_ni & z_mealy_raw;

endmodule

// File: rtl/pair_high_detect_chk.sv
module pair_high_detect_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic x_i,
  input logic z_moore_o,
  input logic z_mealy_o
);

  // Edges since reset release, saturating
  logic [1:0] edges_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              edges_q <= 2'd0;
    else if (edges_q != 2'd3) edges_q <= edges_q + 2'd1;
  end

  always_comb begin
    if (!rst_ni) begin
      p_reset_low_r1: assert (!z_moore_o && !z_mealy_o)
        else $error("outputs high during reset");
    end
  end

  p_moore_pair_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edges_q >= 2'd2) |-> (z_moore_o == ($past(x_i) && $past(x_i, 2))))
    else $error("registered flag mismatch");

  p_moore_needs_two_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    z_moore_o |-> ($past(x_i) && (edges_q >= 2'd2)))
    else $error("registered flag without two samples");

  p_mealy_arc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edges_q >= 2'd1) |-> (z_mealy_o == ($past(x_i) && x_i)))
    else $error("early flag mismatch");

  p_lag_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edges_q >= 2'd1) |-> (z_moore_o == $past(z_mealy_o)))
    else $error("registered flag not one cycle behind");

  p_mealy_low_x_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !x_i |-> !z_mealy_o)
    else $error("early flag high with input low");

  p_run_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (z_moore_o && x_i) |=> z_moore_o)
    else $error("registered flag dropped during run");

endmodule

bind pair_high_detect pair_high_detect_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .x_i       (x_i),
  .z_moore_o (z_moore_o),
  .z_mealy_o (z_mealy_o)
);

// File: tb/pair_high_detect_tb.sv
module pair_high_detect_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic x = 1'b0;
  logic z_moore, z_mealy;

  int n_run = 0;
  int n_fail = 0;
  bit hist[$];
  bit prev_mealy_exp = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pair_high_detect u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .x_i       (x),
    .z_moore_o (z_moore),
    .z_mealy_o (z_mealy)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  function automatic bit exp_moore();
    return hist.size() >= 2 && hist[hist.size()-1] && hist[hist.size()-2];
  endfunction

  function automatic bit exp_mealy(input bit v);
    return hist.size() >= 1 && hist[hist.size()-1] && v;
  endfunction

  // Drive v for one cycle; optionally toggle low then back mid-cycle
  task automatic step(input bit v, input bit glitch, input string req);
    bit mo;
    @(negedge clk);
    x = v;
    #1;
    mo = exp_moore();
    check({req, " moore"}, z_moore, mo);
    check({req, " mealy"}, z_mealy, exp_mealy(v));
    if (hist.size() >= 2) check("R4 lag", z_moore, prev_mealy_exp);
    if (glitch) begin
      x = ~v; #1;
      check("R5 moore stable", z_moore, mo);
      check("R6 mealy follows", z_mealy, exp_mealy(~v));
      x = v; #1;
      check("R5 moore stable", z_moore, mo);
    end
    prev_mealy_exp = exp_mealy(v);
    @(posedge clk);
    hist.push_back(v);
  endtask

  task automatic do_reset();
    @(negedge clk);
    x = 1'b1;
    rst_n = 1'b0;
    #1;
    check("R1 reset moore", z_moore, 1'b0);
    check("R1 reset mealy", z_mealy, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R1 reset moore", z_moore, 1'b0);
    check("R1 reset mealy", z_mealy, 1'b0);
    x = 1'b0;
    rst_n = 1'b1;
    hist.delete();
    prev_mealy_exp = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    do_reset();
    // R7: isolated pulses
    step(0, 0, "R7"); step(1, 0, "R7"); step(0, 0, "R7");
    step(1, 1, "R7"); step(0, 0, "R7"); step(0, 0, "R7");
    // R8: sustained high
    for (int i = 0; i < 8; i++) step(1, 0, "R8");
    step(0, 0, "R8");
    // R2/R3: pairs and alternation
    for (int i = 0; i < 6; i++) step(i[0], 0, "R2");
    step(1, 0, "R2"); step(1, 1, "R3"); step(1, 1, "R3"); step(0, 1, "R3");
    // R1: reset in middle of a run
    step(1, 0, "R2"); step(1, 0, "R2");
    do_reset();
    step(1, 0, "R1"); step(1, 0, "R1"); step(1, 0, "R1");
    // Pseudo-random stream
    lfsr = 8'hA5;
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0], lfsr[3], "R2");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule